// File: doc/BRIEF.md
# Graphics Plane Pixel Format Expander

This block sits behind the pixel fetch of a graphics plane. Each beat carries one raw pixel word and the format settings of the plane: a 5-bit format code, a byte-reversal flag, an alpha-at-low-end flag and an alpha-range flag. It returns the pixel as one common 32-bit word: alpha in the top byte, then three 8-bit colour components. RGB and alpha-RGB packings are unpacked. Narrow components are widened to 8 bits. Alpha is either produced, widened or rescaled, depending on the format. Luma/chroma formats pass through without colour conversion. The 8-bit indexed format is handed on as a bare index for a palette stage further down the pipe.

The block has one register stage and a valid/ready handshake on both sides. With the output side always ready, it accepts one pixel per clock. A code that is not in the supported set gives an all-zero pixel and raises a one-cycle error flag.

Top module: `plane_pix_expander`

## Requirements
- R1: A pixel is accepted in a cycle where `inValid` and `inReady` are both high, and its result is on `outPix` with `outValid` high in the next cycle. `inReady` is high whenever `outValid` is low or `outReady` is high.
- R2: While `outValid` is high and `outReady` is low, `outValid` stays high and `outPix` does not change.
- R3: The output word is alpha in [31:24], then R (or Y) in [23:16], G (or Cb) in [15:8] and B (or Cr) in [7:0]. Code 0x05 with both flags clear reads alpha from [31:24], R from [23:16], G from [15:8] and B from [7:0].
- R4: `byteSwap` reverses the byte order of the bytes the pixel occupies before decoding. That is 2 bytes for codes 0x00, 0x06 and 0x07, 3 bytes for codes 0x01, 0x04 and 0x10, and 4 bytes for codes 0x02, 0x05, 0x12 and 0x15. It has no effect on code 0x0B. Code 0x05 with both flags set therefore decodes a word holding A,B,G,R from the top byte down.
- R5: `alphaSwap` places the alpha field (or the unused byte of code 0x02) at the low end of the pixel, with the colour bits packed above it. Code 0x04 then has alpha in [7:0] and 565 colour in [23:8]. Codes 0x05 and 0x15 have alpha in [7:0] and colour in [31:8]. Code 0x06 has its alpha bit at [0] and 555 colour in [15:1]. Code 0x07 has alpha in [3:0] and 444 colour in [15:4]. It has no effect on codes 0x00, 0x01, 0x0B, 0x10 and 0x12.
- R6: 5-, 6- and 4-bit components are widened to 8 bits by copying their top bits into the freed low bits. 565 is laid out R[15:11] G[10:5] B[4:0], or in [23:8] for code 0x04 with alphaSwap set.
- R7: Codes without an alpha field (0x00, 0x01, 0x02, 0x10) give alpha 0xFF.
- R8: Code 0x06 turns its alpha bit into 0x00 or 0xFF. Code 0x07 widens its 4-bit alpha by repetition.
- R9: For codes 0x04, 0x05 and 0x15, `alphaFull` high passes the 8-bit alpha unchanged. `alphaFull` low maps it to min(255, 2a − (a >> 7)), so 128 becomes 255. `alphaFull` has no effect on any other code.
- R10: Code 0x10 passes its three bytes to [23:0] with alpha 0xFF. Code 0x12 passes the (byte-swapped) 32-bit word unchanged. Code 0x15 is decoded like code 0x05.
- R11: Code 0x0B gives {0xFF, 0x00, 0x00, index}, where the index is bits [7:0] of the input word.
- R12: Any code outside the supported set gives `outPix` = 0. `fmtErr` is high only in the first cycle that such a result is presented, and low in every other cycle.
- R13: After reset `outValid`, `fmtErr` and `outPix` are 0 and `inReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Input pixel valid |
| inReady | output | 1 | Block can take a pixel |
| pixWord | input | 32 | Raw fetched pixel word |
| fmtCode | input | 5 | Pixel format code |
| byteSwap | input | 1 | Reverse the pixel's byte order |
| alphaSwap | input | 1 | Alpha field at the low end |
| alphaFull | input | 1 | 8-bit alpha already spans 0..255 |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Consumer takes the output pixel |
| outPix | output | 32 | Expanded alpha and colour pixel |
| fmtErr | output | 1 | One-cycle flag for an unsupported code |

## Verification
The hardest situation to reach from the ports is an unsupported code landing in the register while the consumer stalls, right before or after good pixels. The flag must fall after one cycle while the zero pixel is still held. When two bad pixels follow each other in a stream, the flag must rise again.

Directed transfers hold `outReady` low for several cycles after bad codes. A streaming phase keeps `outReady` high and interleaves bad and good codes back to back. Random phases draw codes from a mix biased toward the supported set and vary the three flags. The alpha corners 0, 127, 128, 129 and 255 are driven with `alphaFull` both ways.

// File: rtl/plane_pix_pkg.sv
package plane_pix_pkg;

  localparam int PIX_W  = 32;
  localparam int COMP_W = 8;
  localparam int CODE_W = 5;

  typedef enum logic [CODE_W-1:0] {
    FMT_RGB565   = 5'h00,
    FMT_RGB888   = 5'h01,
    FMT_XRGB32   = 5'h02,
    FMT_ARGB8565 = 5'h04,
    FMT_ARGB8888 = 5'h05,
    FMT_ARGB1555 = 5'h06,
    FMT_ARGB4444 = 5'h07,
    FMT_INDEX8   = 5'h0B,
    FMT_YUV888   = 5'h10,
    FMT_YUV422   = 5'h12,
    FMT_AYUV8888 = 5'h15
  } fmt_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic load;
    logic zeroOut;
  } ctlStrobes_t;

  function automatic logic codeSupported(input logic [CODE_W-1:0] code);
    case (code)
      FMT_RGB565, FMT_RGB888, FMT_XRGB32, FMT_ARGB8565, FMT_ARGB8888,
      FMT_ARGB1555, FMT_ARGB4444, FMT_INDEX8, FMT_YUV888, FMT_YUV422,
      FMT_AYUV8888: codeSupported = 1'b1;
      default:      codeSupported = 1'b0;
    endcase
  endfunction

  function automatic logic [COMP_W-1:0] widen5(input logic [4:0] x);
    widen5 = {x, x[4:2]};
  endfunction

  function automatic logic [COMP_W-1:0] widen6(input logic [5:0] x);
    widen6 = {x, x[5:4]};
  endfunction

  function automatic logic [COMP_W-1:0] widen4(input logic [3:0] x);
    widen4 = {x, x};
  endfunction

  // Rescale 0..128 alpha to 0..255, saturating.
  function automatic logic [COMP_W-1:0] rescaleAlpha(input logic [COMP_W-1:0] a);
    logic [COMP_W:0] t;
    t = {a, 1'b0} - {{COMP_W{1'b0}}, a[COMP_W-1]};
    rescaleAlpha = t[COMP_W] ? {COMP_W{1'b1}} : t[COMP_W-1:0];
  endfunction

endpackage

// File: rtl/plane_pix_ctl.sv
module plane_pix_ctl
  import plane_pix_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [CODE_W-1:0] fmtCode,
  input  logic              outReady,
  output logic              inReady,
  output logic              outValid,
  output logic              fmtErr,
  output ctlStrobes_t       strobes
);

  logic take;

  assign inReady = !outValid || outReady;
  assign take    = inValid && inReady;

  always_comb begin
    strobes.load    = take;
    strobes.zeroOut = !codeSupported(fmtCode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      fmtErr   <= 1'b0;
    end else begin
      if (take)          outValid <= 1'b1;
      else if (outReady) outValid <= 1'b0;
      fmtErr <= take && !codeSupported(fmtCode);
    end
  end

endmodule

// File: rtl/plane_pix_dp.sv
module plane_pix_dp
  import plane_pix_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       strobes,
  input  logic [PIX_W-1:0]  pixWord,
  input  logic [CODE_W-1:0] fmtCode,
  input  logic              byteSwap,
  input  logic              alphaSwap,
  input  logic              alphaFull,
  output logic [PIX_W-1:0]  outPix
);

  localparam int NB_MAX = PIX_W / COMP_W;

  logic [PIX_W-1:0]  w;
  logic [PIX_W-1:0]  decoded;
  logic [COMP_W-1:0] a8;
  logic [15:0]       c16;
  logic [23:0]       c24;
  logic [14:0]       c15;
  logic [11:0]       c12;
  logic [2:0]        nBytes;

  // Bytes occupied by one pixel of each format.
  always_comb begin
    case (fmtCode)
      FMT_RGB565, FMT_ARGB1555, FMT_ARGB4444: nBytes = 3'd2;
      FMT_RGB888, FMT_ARGB8565, FMT_YUV888:   nBytes = 3'd3;
      FMT_INDEX8:                             nBytes = 3'd1;
      default:                                nBytes = 3'(NB_MAX);
    endcase
  end

  always_comb begin
    w = pixWord;
    if (byteSwap) begin
      case (nBytes)
        3'd2:    w[15:0] = {pixWord[7:0], pixWord[15:8]};
        3'd3:    w[23:0] = {pixWord[7:0], pixWord[15:8], pixWord[23:16]};
        3'd4:    w = {pixWord[7:0], pixWord[15:8], pixWord[23:16], pixWord[31:24]};
        default: w = pixWord;
      endcase
    end
  end

  always_comb begin
    decoded = '0;
    a8  = '0;
    c16 = '0;
    c24 = '0;
    c15 = '0;
    c12 = '0;
    case (fmtCode)
      FMT_RGB565:
        decoded = {8'hFF, widen5(w[15:11]), widen6(w[10:5]), widen5(w[4:0])};
      FMT_RGB888, FMT_YUV888:
        decoded = {8'hFF, w[23:0]};
      FMT_XRGB32: begin
        c24 = alphaSwap ? w[31:8] : w[23:0];
        decoded = {8'hFF, c24};
      end
      FMT_ARGB8565: begin
        a8  = alphaSwap ? w[7:0]  : w[23:16];
        c16 = alphaSwap ? w[23:8] : w[15:0];
        decoded = {alphaFull ? a8 : rescaleAlpha(a8),
                   widen5(c16[15:11]), widen6(c16[10:5]), widen5(c16[4:0])};
      end
      FMT_ARGB8888, FMT_AYUV8888: begin
        a8  = alphaSwap ? w[7:0]  : w[31:24];
        c24 = alphaSwap ? w[31:8] : w[23:0];
        decoded = {alphaFull ? a8 : rescaleAlpha(a8), c24};
      end
      FMT_ARGB1555: begin
        a8  = {COMP_W{alphaSwap ? w[0] : w[15]}};
        c15 = alphaSwap ? w[15:1] : w[14:0];
        decoded = {a8, widen5(c15[14:10]), widen5(c15[9:5]), widen5(c15[4:0])};
      end
      FMT_ARGB4444: begin
        a8  = widen4(alphaSwap ? w[3:0] : w[15:12]);
        c12 = alphaSwap ? w[15:4] : w[11:0];
        decoded = {a8, widen4(c12[11:8]), widen4(c12[7:4]), widen4(c12[3:0])};
      end
      FMT_INDEX8:
        decoded = {8'hFF, 16'h0000, w[7:0]};
      FMT_YUV422:
        decoded = w;
      default:
        decoded = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            outPix <= '0;
    else if (strobes.load) outPix <= strobes.zeroOut ? '0 : decoded;
  end

endmodule

// File: rtl/plane_pix_expander.sv
module plane_pix_expander
  import plane_pix_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  output logic        inReady,
  input  logic [31:0] pixWord,
  input  logic [4:0]  fmtCode,
  input  logic        byteSwap,
  input  logic        alphaSwap,
  input  logic        alphaFull,
  output logic        outValid,
  input  logic        outReady,
  output logic [31:0] outPix,
  output logic        fmtErr
);

  ctlStrobes_t strobes;

  plane_pix_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .fmtCode  (fmtCode),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .fmtErr   (fmtErr),
    .strobes  (strobes)
  );

  plane_pix_dp u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .pixWord   (pixWord),
    .fmtCode   (fmtCode),
    .byteSwap  (byteSwap),
    .alphaSwap (alphaSwap),
    .alphaFull (alphaFull),
    .outPix    (outPix)
  );

endmodule

// File: rtl/plane_pix_expander_chk.sv
module plane_pix_expander_chk
  import plane_pix_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        inValid,
  input logic        inReady,
  input logic [4:0]  fmtCode,
  input logic        outValid,
  input logic        outReady,
  input logic [31:0] outPix,
  input logic        fmtErr
);

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady |=> outValid);

  assert_backpressure_R1: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |-> !inReady);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(outPix));

  assert_err_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fmtErr |-> outValid && outPix == 32'h0);

  assert_err_raise_R12: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady && !codeSupported(fmtCode) |=> fmtErr);

  assert_err_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fmtErr && !outReady |=> !fmtErr);

  assert_index_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady && fmtCode == 5'h0B |=> outPix[31:8] == 24'hFF0000);

  assert_opaque_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady && (fmtCode == 5'h00 || fmtCode == 5'h01 ||
                           fmtCode == 5'h02 || fmtCode == 5'h10)
    |=> outPix[31:24] == 8'hFF);

endmodule

bind plane_pix_expander plane_pix_expander_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .inReady  (inReady),
  .fmtCode  (fmtCode),
  .outValid (outValid),
  .outReady (outReady),
  .outPix   (outPix),
  .fmtErr   (fmtErr)
);

// File: tb/plane_pix_expander_bench.sv
module plane_pix_expander_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] pixWord = '0;
  logic [4:0]  fmtCode = '0;
  logic        byteSwap = 1'b0;
  logic        alphaSwap = 1'b0;
  logic        alphaFull = 1'b0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [31:0] outPix;
  logic        fmtErr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  plane_pix_expander u_plane_pix_expander (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .pixWord(pixWord), .fmtCode(fmtCode), .byteSwap(byteSwap),
    .alphaSwap(alphaSwap), .alphaFull(alphaFull), .outValid(outValid),
    .outReady(outReady), .outPix(outPix), .fmtErr(fmtErr)
  );

  function automatic int scaleA(int a, bit af);
    int t;
    if (af) return a;
    t = 2 * a - a / 128;
    return (t > 255) ? 255 : t;
  endfunction

  function automatic int w5(int x); return (x * 8) + (x / 4); endfunction
  function automatic int w6(int x); return (x * 4) + (x / 16); endfunction
  function automatic int w4(int x); return x * 17; endfunction

  // Returns {error, pixel} from the requirement text.
  function automatic logic [32:0] refModel(logic [31:0] word, logic [4:0] code,
                                           bit bs, bit as, bit af);
    int nb, a, r, g, b, col;
    logic [31:0] w;
    nb = 4;
    if (code == 5'h00 || code == 5'h06 || code == 5'h07) nb = 2;
    if (code == 5'h01 || code == 5'h04 || code == 5'h10) nb = 3;
    if (code == 5'h0B) nb = 1;
    w = word;
    if (bs) for (int i = 0; i < nb; i++) w[8*i +: 8] = word[8*(nb-1-i) +: 8];
    a = 255; r = 0; g = 0; b = 0;
    case (code)
      5'h00: begin r = w5((w >> 11) & 31); g = w6((w >> 5) & 63); b = w5(w & 31); end
      5'h01, 5'h10: begin r = (w >> 16) & 255; g = (w >> 8) & 255; b = w & 255; end
      5'h02: begin
        col = as ? int'(w >> 8) : int'(w & 32'hFFFFFF);
        r = (col >> 16) & 255; g = (col >> 8) & 255; b = col & 255;
      end
      5'h04: begin
        a   = as ? int'(w & 255) : int'((w >> 16) & 255);
        col = as ? int'((w >> 8) & 16'hFFFF) : int'(w & 16'hFFFF);
        a = scaleA(a, af);
        r = w5((col >> 11) & 31); g = w6((col >> 5) & 63); b = w5(col & 31);
      end
      5'h05, 5'h15: begin
        a   = as ? int'(w & 255) : int'(w >> 24);
        col = as ? int'(w >> 8) : int'(w & 32'hFFFFFF);
        a = scaleA(a, af);
        r = (col >> 16) & 255; g = (col >> 8) & 255; b = col & 255;
      end
      5'h06: begin
        a   = (as ? w[0] : w[15]) ? 255 : 0;
        col = as ? int'((w >> 1) & 32'h7FFF) : int'(w & 32'h7FFF);
        r = w5((col >> 10) & 31); g = w5((col >> 5) & 31); b = w5(col & 31);
      end
      5'h07: begin
        a   = w4(as ? int'(w & 15) : int'((w >> 12) & 15));
        col = as ? int'((w >> 4) & 12'hFFF) : int'(w & 12'hFFF);
        r = w4((col >> 8) & 15); g = w4((col >> 4) & 15); b = w4(col & 15);
      end
      5'h0B: b = w & 255;
      5'h12: return {1'b0, w};
      default: return {1'b1, 32'h0};
    endcase
    return {1'b0, a[7:0], r[7:0], g[7:0], b[7:0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One beat with a stall of 'stall' cycles on the output side.
  task automatic xfer(string tag, logic [31:0] word, logic [4:0] code,
                      bit bs, bit as, bit af, int stall);
    logic [32:0] e;
    logic [31:0] held;
    e = refModel(word, code, bs, as, af);
    @(negedge clk);
    check({tag, " R1 inReady"}, 32'(inReady), 32'd1);
    inValid = 1; pixWord = word; fmtCode = code;
    byteSwap = bs; alphaSwap = as; alphaFull = af; outReady = 0;
    @(negedge clk);
    inValid = 0;
    pixWord = ~word;
    check({tag, " R1 outValid"}, 32'(outValid), 32'd1);
    check({tag, " pixel"}, outPix, e[31:0]);
    check({tag, " R12 fmtErr"}, 32'(fmtErr), 32'(e[32]));
    held = outPix;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check({tag, " R2 hold valid"}, 32'(outValid), 32'd1);
      check({tag, " R2 hold pix"}, outPix, held);
      check({tag, " R12 err low"}, 32'(fmtErr), 32'd0);
      check({tag, " R1 no ready"}, 32'(inReady), 32'd0);
    end
    outReady = 1;
    @(negedge clk);
    outReady = 0;
    check({tag, " R1 drained"}, 32'(outValid), 32'd0);
  endtask

  // Back-to-back stream with the consumer always ready.
  task automatic stream(int n, bit biasBad);
    logic [32:0] prevE;
    logic [4:0] code;
    logic [31:0] word;
    bit bs, as, af;
    prevE = '0;
    outReady = 1;
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check("R1 stream valid", 32'(outValid), 32'd1);
        check("R1 stream pix", outPix, prevE[31:0]);
        check("R12 stream err", 32'(fmtErr), 32'(prevE[32]));
        check("R1 stream ready", 32'(inReady), 32'd1);
      end
      if (i < n) begin
        word = $urandom;
        code = (biasBad && (i % 3 != 2)) ? 5'h1F - 5'(i % 2) : 5'($urandom_range(0, 21));
        bs = 1'($urandom); as = 1'($urandom); af = 1'($urandom);
        inValid = 1; pixWord = word; fmtCode = code;
        byteSwap = bs; alphaSwap = as; alphaFull = af;
        prevE = refModel(word, code, bs, as, af);
      end else begin
        inValid = 0;
      end
    end
    @(negedge clk);
    outReady = 0;
  endtask

  initial begin
    logic [4:0] goodCodes [11];
    logic [4:0] c;
    goodCodes = '{5'h00, 5'h01, 5'h02, 5'h04, 5'h05, 5'h06, 5'h07,
                  5'h0B, 5'h10, 5'h12, 5'h15};
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    check("R13 outValid", 32'(outValid), 32'd0);
    check("R13 outPix", outPix, 32'd0);
    check("R13 fmtErr", 32'(fmtErr), 32'd0);
    check("R13 inReady", 32'(inReady), 32'd1);

    xfer("R3 argb8888", 32'h80_11_22_33, 5'h05, 0, 0, 1, 0);
    xfer("R4 R5 abgr8888", 32'hC0_33_22_11, 5'h05, 1, 1, 1, 2);
    xfer("R4 R5 xbgr", 32'h00_33_22_11, 5'h02, 1, 1, 0, 0);
    xfer("R4 rgb565 swap", 32'h0000_1FF8, 5'h00, 1, 0, 0, 0);
    xfer("R5 rgb565 alphaSwap no effect", 32'h0000_F81F, 5'h00, 0, 1, 0, 0);
    xfer("R6 rgb565", 32'h0000_8410, 5'h00, 0, 0, 0, 0);
    xfer("R7 rgb888", 32'hAB_12_34_56, 5'h01, 0, 0, 0, 0);
    xfer("R8 argb1555 a1", 32'h0000_FC00, 5'h06, 0, 0, 0, 0);
    xfer("R8 argb1555 a0 swapped", 32'h0000_FFFE, 5'h06, 0, 1, 0, 0);
    xfer("R8 argb4444", 32'h0000_9A5F, 5'h07, 0, 0, 0, 0);
    xfer("R5 argb4444 low alpha", 32'h0000_A5F9, 5'h07, 0, 1, 0, 0);
    xfer("R5 argb8565 low alpha", 32'h00_F8_1F_80, 5'h04, 0, 1, 0, 0);
    foreach (goodCodes[i]) begin end
    xfer("R9 alpha 0", 32'h00_01_02_03, 5'h05, 0, 0, 0, 0);
    xfer("R9 alpha 127", 32'h7F_01_02_03, 5'h05, 0, 0, 0, 0);
    xfer("R9 alpha 128", 32'h80_01_02_03, 5'h05, 0, 0, 0, 0);
    xfer("R9 alpha 129", 32'h81_01_02_03, 5'h05, 0, 0, 0, 0);
    xfer("R9 alpha 255", 32'hFF_01_02_03, 5'h15, 0, 0, 0, 0);
    xfer("R9 alphaFull on 4444 no effect", 32'h0000_9A5F, 5'h07, 0, 0, 1, 0);
    xfer("R10 yuv888", 32'h77_10_80_F0, 5'h10, 0, 0, 0, 0);
    xfer("R10 yuv422", 32'h10_80_EB_40, 5'h12, 0, 0, 0, 0);
    xfer("R10 ayuv", 32'h40_10_80_F0, 5'h15, 0, 0, 0, 0);
    xfer("R11 index", 32'hDE_AD_BE_5A, 5'h0B, 1, 1, 0, 0);
    xfer("R12 code 03", 32'hFF_FF_FF_FF, 5'h03, 0, 0, 1, 3);
    xfer("R12 code 1F", 32'h12_34_56_78, 5'h1F, 1, 1, 0, 1);

    stream(12, 1'b1);
    stream(40, 1'b0);

    for (int n = 0; n < 300; n++) begin
      c = ($urandom_range(0, 3) == 0) ? 5'($urandom) : goodCodes[$urandom_range(0, 10)];
      xfer("R3 random", $urandom, c, 1'($urandom), 1'($urandom), 1'($urandom),
           $urandom_range(0, 2));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule